// File: doc/BRIEF.md
# Paged Receive Ring Buffer Manager

This block places received frames into a circular buffer in local memory. The memory is split into 256-byte pages, and every ring pointer is an 8-bit page number. Frames arrive as a stream of bytes. A status byte comes with the final byte of each frame. The block writes the payload into the ring starting four bytes into the current page. When the frame ends, it goes back and fills those four bytes with a header: the status, the page where the following frame will begin, and the stored length. After that it moves the current page forward and raises a one-cycle "frame stored" event for the interrupt logic.

Four page pointers control the ring: start, stop, current and boundary. The host can write each of them and can read each of them back. The ring covers every page from start up to, but not including, stop. The boundary pointer marks the oldest page the host has not yet consumed. A frame whose data would run into the boundary page is dropped and the ring enters a halted state. In that state every frame is refused until the host moves the boundary. Refused frames, and frames that arrive while monitor mode is on, are counted as missed.

Top module: `rxr_ring_mgr`

## Requirements
- R1: After reset, all four page pointers, `miss_count`, `ring_halted`, `miss_flag`, `mem_we`, `rx_busy` and the three event outputs are zero.
- R2: When `cfg_we` is high at a clock edge, `cfg_wdata` is loaded into the pointer selected by `cfg_sel`: 0 loads start, 1 loads stop, 2 loads current, 3 loads boundary. The new value appears on the matching `ring_*` output after that edge.
- R3: Data byte i of a stored frame (counting from 0) is written to page P and offset (4+i) mod 256. P is the current page advanced by floor((4+i)/256) pages. A page step that reaches the stop page wraps to the start page. Each written byte produces exactly one `mem_we` cycle, and no write falls outside the ring.
- R4: In the four cycles right after the last data write, the header is written at offsets 0 to 3 of the frame's first page. Offset 0 holds the status, offset 1 holds the next page, offset 2 holds the low byte of (length + 4) and offset 3 holds its high byte.
- R5: `evt_rx_done` pulses for one cycle. It rises on the sixth falling clock edge after the last byte was presented (one cycle after the final header write). On that same edge `ring_curr` changes to current + ceil((length+4)/256), wrapped into the ring.
- R6: A data byte that would be written at offset 0 of the boundary page is not written. Instead, `evt_overwrite` pulses, `ring_halted` is set, the rest of the frame is dropped and `ring_curr` does not change.
- R7: When a frame is dropped, its last byte causes `evt_missed` to pulse once. At the same edge `miss_count` goes up by one and `miss_flag` is set. The next frame that is stored successfully clears `miss_flag`.
- R8: While `monitor_en` is high at the first byte of a frame, none of that frame is written and the frame is counted as missed.
- R9: While `ring_halted` is set, no frame is written and every frame is counted as missed. Writing the boundary pointer with its existing value leaves the flag set. Writing it with a different value clears the flag.
- R10: `rx_busy` is high from the first header cycle until the completion pulse. Bytes offered while it is high are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Host pointer write strobe |
| cfg_sel | input | 2 | Pointer select: 0 start, 1 stop, 2 current, 3 boundary |
| cfg_wdata | input | 8 | Page number to load |
| monitor_en | input | 1 | Monitor mode: check frames but never store them |
| rx_valid | input | 1 | A received byte is present |
| rx_data | input | 8 | Received byte |
| rx_last | input | 1 | Marks the final byte of the frame |
| rx_status | input | 8 | Receive status, sampled with the last byte |
| rx_busy | output | 1 | Header write-back in progress; bytes are ignored |
| ring_start | output | 8 | Start page |
| ring_stop | output | 8 | Stop page (exclusive) |
| ring_curr | output | 8 | Page where the next frame begins |
| ring_bnd | output | 8 | Boundary page |
| mem_we | output | 1 | Local memory write strobe |
| mem_addr | output | 16 | Write address {page, offset} |
| mem_wdata | output | 8 | Write data |
| evt_rx_done | output | 1 | One-cycle pulse: frame stored |
| evt_overwrite | output | 1 | One-cycle pulse: boundary page reached |
| evt_missed | output | 1 | One-cycle pulse: frame not stored |
| ring_halted | output | 1 | Ring halted after an overwrite |
| miss_flag | output | 1 | The most recent frame outcome was a miss |
| miss_count | output | 8 | Missed-frame counter |

## Verification
Some properties are checked on every cycle. Writes stay inside the ring. The completion pulse follows the final header write. The current page moves only on that pulse or on a host write. An overwrite halts the ring and never writes. Each missed pulse moves the counter by exactly one. A halted ring makes no writes. The exact placement of data across a page wrap and the header contents can only be shown by the bench's scenarios, because they depend on the frame length. The same holds for the next-page value, for clearing the halt when the boundary moves, and for bytes being ignored while busy.

// File: rtl/rxr_pkg.sv
`timescale 1ns/1ps
package rxr_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_DATA,
        ST_DROP,
        ST_HDR,
        ST_DONE
    } rxr_state_e;

    localparam logic [1:0] SEL_START = 2'd0;
    localparam logic [1:0] SEL_STOP  = 2'd1;
    localparam logic [1:0] SEL_CURR  = 2'd2;
    localparam logic [1:0] SEL_BND   = 2'd3;

    localparam int HDR_LEN = 4;

endpackage

// File: rtl/rxr_page_step.sv
`timescale 1ns/1ps
// Advances a page number by one and wraps it back to the start page.
module rxr_page_step #(
    parameter int PAGE_W = 8
) (
    input  logic [PAGE_W-1:0] page_i,
    input  logic [PAGE_W-1:0] start_i,
    input  logic [PAGE_W-1:0] stop_i,
    output logic [PAGE_W-1:0] page_o
);
    logic [PAGE_W:0] inc;

    assign inc    = {1'b0, page_i} + 1'b1;
    assign page_o = (inc >= {1'b0, stop_i}) ? start_i : inc[PAGE_W-1:0];
endmodule

// File: rtl/rxr_hdr_byte.sv
`timescale 1ns/1ps
// Selects one byte of the frame header by its index.
module rxr_hdr_byte #(
    parameter int DATA_W = 8,
    parameter int LEN_W  = 16
) (
    input  logic [1:0]        idx_i,
    input  logic [DATA_W-1:0] status_i,
    input  logic [DATA_W-1:0] next_i,
    input  logic [LEN_W-1:0]  len_i,
    output logic [DATA_W-1:0] byte_o
);
    localparam int HDR = rxr_pkg::HDR_LEN;

    logic [LEN_W-1:0] count;

    assign count = len_i + LEN_W'(HDR);

    always_comb begin
        case (idx_i)
            2'd0:    byte_o = status_i;
            2'd1:    byte_o = next_i;
            2'd2:    byte_o = count[DATA_W-1:0];
            default: byte_o = count[2*DATA_W-1:DATA_W];
        endcase
    end
endmodule

// File: rtl/rxr_event_count.sv
`timescale 1ns/1ps
// Event counter. The SAT parameter chooses between saturating and wrapping.
module rxr_event_count #(
    parameter int CNT_W = 8,
    parameter bit SAT   = 1'b0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inc_i,
    output logic [CNT_W-1:0] cnt_o
);
    logic [CNT_W-1:0] cnt_d, cnt_q;

    generate
        if (SAT) begin : g_sat
            always_comb begin
                cnt_d = cnt_q;
                if (inc_i && (cnt_q != {CNT_W{1'b1}})) cnt_d = cnt_q + 1'b1;
            end
        end else begin : g_wrap
            always_comb begin
                cnt_d = cnt_q;
                if (inc_i) cnt_d = cnt_q + 1'b1;
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign cnt_o = cnt_q;
endmodule

// File: rtl/rxr_ring_mgr.sv
`timescale 1ns/1ps
module rxr_ring_mgr #(
    parameter int OFF_W = 8,
    parameter int CNT_W = 8,
    parameter int LEN_W = 16
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  cfg_we,
    input  logic [1:0]            cfg_sel,
    input  logic [7:0]            cfg_wdata,
    input  logic                  monitor_en,
    input  logic                  rx_valid,
    input  logic [7:0]            rx_data,
    input  logic                  rx_last,
    input  logic [7:0]            rx_status,
    output logic                  rx_busy,
    output logic [7:0]            ring_start,
    output logic [7:0]            ring_stop,
    output logic [7:0]            ring_curr,
    output logic [7:0]            ring_bnd,
    output logic                  mem_we,
    output logic [8+OFF_W-1:0]    mem_addr,
    output logic [7:0]            mem_wdata,
    output logic                  evt_rx_done,
    output logic                  evt_overwrite,
    output logic                  evt_missed,
    output logic                  ring_halted,
    output logic                  miss_flag,
    output logic [CNT_W-1:0]      miss_count
);
    import rxr_pkg::*;

    localparam int DATA_W = 8;
    localparam int PAGE_W = DATA_W;
    localparam int ADDR_W = PAGE_W + OFF_W;

    typedef struct packed {
        rxr_state_e          state;
        logic [PAGE_W-1:0]   pstart;
        logic [PAGE_W-1:0]   pstop;
        logic [PAGE_W-1:0]   curr;
        logic [PAGE_W-1:0]   bnd;
        logic [PAGE_W-1:0]   wr_page;
        logic [OFF_W-1:0]    wr_off;
        logic [LEN_W-1:0]    len;
        logic [DATA_W-1:0]   status;
        logic [PAGE_W-1:0]   nxt;
        logic [1:0]          hidx;
        logic                mem_we;
        logic [ADDR_W-1:0]   mem_addr;
        logic [DATA_W-1:0]   mem_wdata;
        logic                prx;
        logic                ovw;
        logic                miss;
        logic                halted;
        logic                miss_flag;
    } rxr_regs_t;

    rxr_regs_t d, q;

    logic [PAGE_W-1:0] cur_pg;
    logic [OFF_W-1:0]  cur_off;
    logic [PAGE_W-1:0] step_pg;
    logic [DATA_W-1:0] hdr_byte;
    logic              drop;

    assign cur_pg  = (q.state == ST_IDLE) ? q.curr : q.wr_page;
    assign cur_off = (q.state == ST_IDLE) ? OFF_W'(HDR_LEN) : q.wr_off;

    rxr_page_step #(.PAGE_W(PAGE_W)) u_step (
        .page_i  (cur_pg),
        .start_i (q.pstart),
        .stop_i  (q.pstop),
        .page_o  (step_pg)
    );

    rxr_hdr_byte #(.DATA_W(DATA_W), .LEN_W(LEN_W)) u_hdr (
        .idx_i    (q.hidx),
        .status_i (q.status),
        .next_i   (q.nxt),
        .len_i    (q.len),
        .byte_o   (hdr_byte)
    );

    always_comb begin
        d        = q;
        d.mem_we = 1'b0;
        d.prx    = 1'b0;
        d.ovw    = 1'b0;
        d.miss   = 1'b0;
        drop     = 1'b0;

        // Host pointer writes; frame completion below takes precedence on curr.
        if (cfg_we) begin
            case (cfg_sel)
                SEL_START: d.pstart = cfg_wdata;
                SEL_STOP:  d.pstop  = cfg_wdata;
                SEL_CURR:  d.curr   = cfg_wdata;
                default: begin
                    if (cfg_wdata != q.bnd) d.halted = 1'b0;
                    d.bnd = cfg_wdata;
                end
            endcase
        end

        case (q.state)
            ST_IDLE, ST_DATA: begin
                if (rx_valid) begin
                    d.len = (q.state == ST_IDLE) ? LEN_W'(1) : q.len + 1'b1;
                    if ((q.state == ST_IDLE) && (monitor_en || q.halted)) begin
                        drop = 1'b1;
                    end else if ((cur_off == '0) && (cur_pg == q.bnd)) begin
                        d.ovw    = 1'b1;
                        d.halted = 1'b1;
                        drop     = 1'b1;
                    end else begin
                        d.mem_we    = 1'b1;
                        d.mem_addr  = {cur_pg, cur_off};
                        d.mem_wdata = rx_data;
                        d.wr_off    = cur_off + 1'b1;
                        d.wr_page   = (d.wr_off == '0) ? step_pg : cur_pg;
                        if (rx_last) begin
                            d.status = rx_status;
                            d.nxt    = step_pg;
                            d.hidx   = 2'd0;
                            d.state  = ST_HDR;
                        end else begin
                            d.state  = ST_DATA;
                        end
                    end
                    if (drop) begin
                        if (rx_last) begin
                            d.miss      = 1'b1;
                            d.miss_flag = 1'b1;
                            d.state     = ST_IDLE;
                        end else begin
                            d.state     = ST_DROP;
                        end
                    end
                end
            end
            ST_DROP: begin
                if (rx_valid && rx_last) begin
                    d.miss      = 1'b1;
                    d.miss_flag = 1'b1;
                    d.state     = ST_IDLE;
                end
            end
            ST_HDR: begin
                d.mem_we    = 1'b1;
                d.mem_addr  = {q.curr, {(OFF_W-2){1'b0}}, q.hidx};
                d.mem_wdata = hdr_byte;
                d.hidx      = q.hidx + 1'b1;
                if (q.hidx == 2'd3) d.state = ST_DONE;
            end
            ST_DONE: begin
                d.curr      = q.nxt;
                d.prx       = 1'b1;
                d.miss_flag = 1'b0;
                d.state     = ST_IDLE;
            end
            default: d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q       <= '0;
            q.state <= ST_IDLE;
        end else begin
            q       <= d;
        end
    end

    rxr_event_count #(.CNT_W(CNT_W), .SAT(1'b0)) u_miss_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .inc_i (d.miss),
        .cnt_o (miss_count)
    );

    assign rx_busy       = (q.state == ST_HDR) || (q.state == ST_DONE);
    assign ring_start    = q.pstart;
    assign ring_stop     = q.pstop;
    assign ring_curr     = q.curr;
    assign ring_bnd      = q.bnd;
    assign mem_we        = q.mem_we;
    assign mem_addr      = q.mem_addr;
    assign mem_wdata     = q.mem_wdata;
    assign evt_rx_done   = q.prx;
    assign evt_overwrite = q.ovw;
    assign evt_missed    = q.miss;
    assign ring_halted   = q.halted;
    assign miss_flag     = q.miss_flag;
endmodule

// File: rtl/rxr_ring_chk.sv
`timescale 1ns/1ps
module rxr_ring_chk #(
    parameter int OFF_W = 8,
    parameter int CNT_W = 8
) (
    input logic               clk,
    input logic               rst_n,
    input logic               cfg_we,
    input logic [1:0]         cfg_sel,
    input logic               rx_busy,
    input logic [7:0]         ring_start,
    input logic [7:0]         ring_stop,
    input logic [7:0]         ring_curr,
    input logic               mem_we,
    input logic [8+OFF_W-1:0] mem_addr,
    input logic               evt_rx_done,
    input logic               evt_overwrite,
    input logic               evt_missed,
    input logic               ring_halted,
    input logic [CNT_W-1:0]   miss_count
);
    localparam int ADDR_W = 8 + OFF_W;

    // R3: every write lands inside the configured ring
    p_in_ring_r3: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we && (ring_start < ring_stop) && $stable(ring_start) && $stable(ring_stop)
        |-> (mem_addr[ADDR_W-1:OFF_W] >= ring_start) && (mem_addr[ADDR_W-1:OFF_W] < ring_stop));

    // R5: completion follows the final header byte write
    p_done_after_hdr_r5: assert property (@(posedge clk) disable iff (!rst_n)
        evt_rx_done |-> $past(mem_we) && ($past(mem_addr[OFF_W-1:0]) == OFF_W'(3)));

    // R5: current page moves only on completion or a host write
    p_curr_moves_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(ring_curr) && !$past(cfg_we && (cfg_sel == 2'd2)) |-> evt_rx_done);

    // R6: overwrite halts the ring and writes nothing
    p_ovw_halts_r6: assert property (@(posedge clk) disable iff (!rst_n)
        evt_overwrite |-> ring_halted && !mem_we);

    // R7: every missed pulse advances the counter by exactly one
    p_miss_count_r7: assert property (@(posedge clk) disable iff (!rst_n)
        evt_missed |-> miss_count == $past(miss_count) + 1'b1);

    // R7: a stored frame is never also reported as missed or overwritten
    p_event_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
        evt_rx_done |-> !evt_missed && !evt_overwrite);

    // R9: a halted ring stores nothing
    p_halt_no_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ring_halted && $past(ring_halted) |-> !mem_we);

    // R10: header cycles never report a drop
    p_busy_no_drop_r10: assert property (@(posedge clk) disable iff (!rst_n)
        rx_busy |-> !evt_missed && !evt_overwrite);
endmodule

bind rxr_ring_mgr rxr_ring_chk #(.OFF_W(OFF_W), .CNT_W(CNT_W)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .cfg_we        (cfg_we),
    .cfg_sel       (cfg_sel),
    .rx_busy       (rx_busy),
    .ring_start    (ring_start),
    .ring_stop     (ring_stop),
    .ring_curr     (ring_curr),
    .mem_we        (mem_we),
    .mem_addr      (mem_addr),
    .evt_rx_done   (evt_rx_done),
    .evt_overwrite (evt_overwrite),
    .evt_missed    (evt_missed),
    .ring_halted   (ring_halted),
    .miss_count    (miss_count)
);

// File: tb/rxr_ring_mgr_test.sv
`timescale 1ns/1ps
module rxr_ring_mgr_test;
    localparam int START = 8'h40;
    localparam int STOP  = 8'h46;
    localparam int NVEC  = 5;
    // {length[15:0], status[7:0]}
    localparam logic [23:0] VEC [NVEC] = '{
        {16'd60,  8'h01},
        {16'd252, 8'h21},
        {16'd253, 8'h01},
        {16'd600, 8'h03},
        {16'd20,  8'h41}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [1:0]  cfg_sel = '0;
    logic [7:0]  cfg_wdata = '0;
    logic        monitor_en = 1'b0;
    logic        rx_valid = 1'b0;
    logic [7:0]  rx_data = '0;
    logic        rx_last = 1'b0;
    logic [7:0]  rx_status = '0;
    logic        rx_busy;
    logic [7:0]  ring_start, ring_stop, ring_curr, ring_bnd;
    logic        mem_we;
    logic [15:0] mem_addr;
    logic [7:0]  mem_wdata;
    logic        evt_rx_done, evt_overwrite, evt_missed, ring_halted, miss_flag;
    logic [7:0]  miss_count;

    int n_chk = 0, n_fail = 0;
    int wr_cnt = 0, prx_cnt = 0, ovw_cnt = 0, stray_cnt = 0;
    logic [7:0] shadow [0:(STOP-START)*256-1];
    int lat, busy_seen, c0, exp_nxt, bad;

    always #2.5 clk = ~clk;

    rxr_ring_mgr uut (.*);

    // Capture writes and events a little after each rising edge.
    always begin
        @(posedge clk);
        #1;
        if (rst_n) begin
            if (mem_we) begin
                wr_cnt++;
                if (mem_addr >= 16'(START*256) && mem_addr < 16'(STOP*256))
                    shadow[int'(mem_addr) - START*256] = mem_wdata;
                else
                    stray_cnt++;
            end
            if (evt_rx_done) prx_cnt++;
            if (evt_overwrite) ovw_cnt++;
        end
    end

    task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic cfg_write(input logic [1:0] sel, input logic [7:0] val);
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = val;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    function automatic logic [7:0] pat(input int seed, input int i);
        return 8'(seed + i * 7);
    endfunction

    function automatic int shadow_idx(input int pg0, input int i);
        int pos = 4 + i;
        int pg = pg0 + pos / 256;
        while (pg >= STOP) pg -= (STOP - START);
        return (pg - START) * 256 + pos % 256;
    endfunction

    function automatic int next_page(input int pg0, input int len);
        int pg = pg0 + (len + 4 + 255) / 256;
        while (pg >= STOP) pg -= (STOP - START);
        return pg;
    endfunction

    task automatic send(input int len, input logic [7:0] st, input int seed, input bit junk);
        for (int i = 0; i < len; i++) begin
            @(negedge clk);
            rx_valid = 1'b1; rx_data = pat(seed, i);
            rx_last = (i == len - 1); rx_status = st;
        end
        lat = 0; busy_seen = 0;
        for (int k = 0; k < 9; k++) begin
            @(negedge clk);
            if (evt_rx_done && lat == 0) lat = k + 1;
            if (k == 1) busy_seen = rx_busy;
            if (k == 0) begin rx_valid = junk; rx_last = 1'b0; rx_data = 8'hEE; end
            if (k == 3) rx_valid = 1'b0;
        end
    endtask

    task automatic stored_checks(input int len, input logic [7:0] st, input int seed, input int w0);
        bad = 0;
        for (int i = 0; i < len; i++)
            if (shadow[shadow_idx(c0, i)] !== pat(seed, i)) bad++;
        check(bad == 0, "R3", "data byte mismatches", bad, 0);
        check(wr_cnt - w0 == len + 4, "R3", "write count", wr_cnt - w0, len + 4);
        check(shadow[(c0-START)*256+0] == st, "R4", "header status", shadow[(c0-START)*256+0], st);
        check(shadow[(c0-START)*256+1] == 8'(exp_nxt), "R4", "header next page", shadow[(c0-START)*256+1], exp_nxt);
        check(shadow[(c0-START)*256+2] == 8'(len+4), "R4", "header count low", shadow[(c0-START)*256+2], (len+4) & 255);
        check(shadow[(c0-START)*256+3] == 8'((len+4) >> 8), "R4", "header count high", shadow[(c0-START)*256+3], (len+4) >> 8);
        check(lat == 6, "R5", "completion latency", lat, 6);
        check(int'(ring_curr) == exp_nxt, "R5", "next current page", ring_curr, exp_nxt);
        check(busy_seen == 1, "R10", "busy during header", busy_seen, 1);
    endtask

    initial begin
        int w0, m0, p0;
        repeat (3) @(negedge clk);
        // R1: reset state
        check(ring_start == 0 && ring_stop == 0 && ring_curr == 0 && ring_bnd == 0, "R1", "pointers after reset", ring_curr, 0);
        check(miss_count == 0 && !ring_halted && !miss_flag, "R1", "counter and flags after reset", miss_count, 0);
        check(!mem_we && !rx_busy && !evt_rx_done && !evt_overwrite && !evt_missed, "R1", "strobes after reset", mem_we, 0);
        rst_n = 1'b1;

        // R2: pointer programming
        cfg_write(2'd0, 8'(START));
        cfg_write(2'd1, 8'(STOP));
        cfg_write(2'd2, 8'(START));
        cfg_write(2'd3, 8'(START));
        check(ring_start == 8'(START), "R2", "start readback", ring_start, START);
        check(ring_stop == 8'(STOP), "R2", "stop readback", ring_stop, STOP);
        check(ring_curr == 8'(START) && ring_bnd == 8'(START), "R2", "curr/bnd readback", ring_bnd, START);

        // Vector table: stored frames, including exact page fill and data wrap
        for (int v = 0; v < NVEC; v++) begin
            c0 = ring_curr;
            cfg_write(2'd3, 8'(c0));
            exp_nxt = next_page(c0, int'(VEC[v][23:8]));
            w0 = wr_cnt;
            send(int'(VEC[v][23:8]), VEC[v][7:0], v * 31 + 5, 1'b0);
            stored_checks(int'(VEC[v][23:8]), VEC[v][7:0], v * 31 + 5, w0);
        end
        check(stray_cnt == 0, "R3", "writes outside ring", stray_cnt, 0);

        // R6: overwrite when entering the boundary page (current 42, boundary 43)
        cfg_write(2'd3, 8'h43);
        w0 = wr_cnt; m0 = miss_count; p0 = prx_cnt;
        send(300, 8'h01, 9, 1'b0);
        check(wr_cnt - w0 == 252, "R6", "bytes written before boundary", wr_cnt - w0, 252);
        check(ovw_cnt == 1, "R6", "overwrite pulses", ovw_cnt, 1);
        check(ring_halted == 1, "R6", "halted flag", ring_halted, 1);
        check(ring_curr == 8'h42, "R6", "current page unchanged", ring_curr, 8'h42);
        check(prx_cnt == p0, "R6", "no completion pulse", prx_cnt - p0, 0);
        check(int'(miss_count) == m0 + 1, "R7", "miss count after overwrite", miss_count, m0 + 1);
        check(miss_flag == 1, "R7", "miss flag set", miss_flag, 1);

        // R9: halted ring refuses frames
        w0 = wr_cnt;
        send(10, 8'h01, 3, 1'b0);
        check(wr_cnt == w0, "R9", "writes while halted", wr_cnt - w0, 0);
        check(int'(miss_count) == m0 + 2, "R9", "miss count while halted", miss_count, m0 + 2);
        cfg_write(2'd3, 8'h43);
        check(ring_halted == 1, "R9", "same boundary keeps halt", ring_halted, 1);
        cfg_write(2'd3, 8'h44);
        check(ring_halted == 0, "R9", "moved boundary clears halt", ring_halted, 0);

        // R8: monitor mode
        monitor_en = 1'b1;
        w0 = wr_cnt;
        send(30, 8'h01, 4, 1'b0);
        monitor_en = 1'b0;
        check(wr_cnt == w0, "R8", "writes in monitor mode", wr_cnt - w0, 0);
        check(int'(miss_count) == m0 + 3, "R8", "monitor frame counted missed", miss_count, m0 + 3);
        check(ring_curr == 8'h42, "R8", "current page after monitor", ring_curr, 8'h42);

        // R10 and R7: bytes during header ignored; a good frame clears the miss flag
        c0 = 8'h42; exp_nxt = 8'h43;
        w0 = wr_cnt;
        send(50, 8'h05, 77, 1'b1);
        stored_checks(50, 8'h05, 77, w0);
        check(miss_flag == 0, "R7", "miss flag cleared by stored frame", miss_flag, 0);
        check(stray_cnt == 0, "R3", "writes outside ring at end", stray_cnt, 0);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule